// File: doc/BRIEF.md
# SPI Master Serial Shift Engine

This block is the serial core of a synchronous-serial bus master. It takes data words from a transmit FIFO, shifts them out MSB first on `mosi` and captures `miso` into receive words, which it pushes into a receive FIFO. Only Motorola-style SPI framing is supported. The configuration inputs set the frame length, the clock phase and idle polarity, and the transfer direction. A divider sets the serial clock rate, and a one-hot vector picks the slave select line to drive.

The engine samples its configuration only while `enable` is low, so software sets up a transfer and then raises `enable`. A burst starts as soon as the transmit FIFO holds a word. Frames then run back to back while words remain, and the select line stays low for the whole burst. In receive-only mode, one queued word starts the burst and is thrown away. The engine then clocks a programmed number of frames while it shifts out zeros. Dropping `enable` stops the engine at once and flushes both FIFOs.

Top module: `spi_shift_master`

## Requirements
- R1: The frame length is `ctrl_word[3:0]` + 1 bits, from 1 to 16. This includes 8- and 16-bit words. The low frame bits of `tx_data` go out MSB first on `mosi`, and `mosi` is 0 while no burst is active.
- R2: `sclk` idles at `ctrl_word[7]`. When `ctrl_word[6]` is 0, the first bit is on `mosi` before the first edge, `miso` is sampled on leading edges, and `mosi` changes on trailing edges. When `ctrl_word[6]` is 1, `mosi` changes on leading edges and `miso` is sampled on trailing edges.
- R3: Each `sclk` half period lasts `clk_div`/2 clock cycles, and bit 0 of `clk_div` is ignored. A divider below 2 starts no transfer.
- R4: `ctrl_word[9:8]` selects the direction. A value of 0 or 3 means transmit and receive. A value of 1 means transmit only, with no `rx_push`. A value of 2 means receive only.
- R5: In receive-only mode, a transmit-FIFO word starts the burst. That word is popped and discarded. The engine then clocks `frame_cnt`+1 frames with `mosi` held at 0 and pushes every received word.
- R6: `ss_n` equals the inverse of `slave_sel` from the cycle a burst loads its first frame until the last frame completes, and is all ones otherwise. The next word is popped in the cycle the previous frame ends, which keeps the frames back to back with one idle half period between them.
- R7: `busy` is high while a burst is active or the transmit FIFO is not empty.
- R8: `ctrl_word`, `clk_div`, `slave_sel` and `frame_cnt` are captured only in cycles where `enable` is low. Changes made while `enable` is high have no effect.
- R9: When `enable` is low, the next cycle shows an idle engine: `ss_n` all ones and `sclk` at the idle level. While `enable` is low, `fifo_flush` is high.
- R10: If `ctrl_word[5:4]` is not 0, no transfer starts and the queued word stays in the FIFO.
- R11: `rx_push` pulses for one cycle, in the cycle after the final `sclk` edge of a frame. At the same time `rx_data` holds the received bits right-aligned, with the upper bits set to zero.
- R12: During reset, `ss_n` is all ones and `sclk`, `mosi`, `tx_pop` and `rx_push` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Global run enable; low halts, flushes and admits configuration |
| ctrl_word | input | 10 | Frame size - 1, format, phase, polarity, direction |
| clk_div | input | DIVW | Serial clock divider (even values) |
| slave_sel | input | SLAVES | One-hot slave select |
| frame_cnt | input | CNTW | Receive-only frame count minus one |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_data | input | 16 | Transmit FIFO head word |
| tx_pop | output | 1 | Pop the transmit FIFO head |
| rx_push | output | 1 | Push `rx_data` into the receive FIFO |
| rx_data | output | 16 | Received word |
| fifo_flush | output | 1 | Flush both FIFOs |
| busy | output | 1 | Burst active or transmit data pending |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | SLAVES | Active-low slave selects |

## Verification
The bench builds the engine with three select lines, a 6-bit divider and a 4-bit frame counter. With a 6-bit divider, odd divisors and the smallest divisor (one clock per half period) are easy to reach, and the frame counter's range in receive-only mode is short. Each test scenario picks a different combination of frame length, phase, polarity, direction and divider. Every cycle, the bench compares all outputs with a behavioural timeline model driven by a pseudo-random `miso` stream.

// File: rtl/spi_shift_master.sv
module spi_shift_master #(
  parameter int SLAVES = 4,
  parameter int DIVW   = 16,
  parameter int CNTW   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [9:0]        ctrl_word,
  input  logic [DIVW-1:0]   clk_div,
  input  logic [SLAVES-1:0] slave_sel,
  input  logic [CNTW-1:0]   frame_cnt,
  input  logic              tx_empty,
  input  logic [15:0]       tx_data,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [15:0]       rx_data,
  output logic              fifo_flush,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [SLAVES-1:0] ss_n
);
  localparam logic [DIVW-2:0] HONE = 1;
  localparam logic [CNTW-1:0] CONE = 1;

  logic [9:0]        cfg_ctrl;
  logic [DIVW-1:0]   cfg_div;
  logic [SLAVES-1:0] cfg_sel;
  logic [CNTW-1:0]   cfg_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cfg_ctrl <= '0;
      cfg_div  <= '0;
      cfg_sel  <= '0;
      cfg_cnt  <= '0;
    end else if (!enable) begin
      cfg_ctrl <= ctrl_word;
      cfg_div  <= clk_div;
      cfg_sel  <= slave_sel;
      cfg_cnt  <= frame_cnt;
    end

  wire [4:0]      size    = {1'b0, cfg_ctrl[3:0]} + 5'd1;
  wire            cpha    = cfg_ctrl[6];
  wire            cpol    = cfg_ctrl[7];
  wire            rx_only = cfg_ctrl[9:8] == 2'd2;
  wire            tx_only = cfg_ctrl[9:8] == 2'd1;
  wire [DIVW-2:0] half    = cfg_div[DIVW-1:1];
  wire            go_ok   = (cfg_ctrl[5:4] == 2'd0) && (half != '0);

  logic            active, sclk_q, mosi_q, push_q;
  logic [DIVW-2:0] hcnt;
  logic [5:0]      edge_i;
  logic [15:0]     sh, rsh, rx_q;
  logic [CNTW-1:0] left;

  wire tick   = active && (hcnt == half - HONE);
  wire lead   = ~edge_i[0];
  wire last   = tick && (edge_i == {size, 1'b0} - 6'd1);
  wire more   = rx_only ? (left != '0) : ~tx_empty;
  wire start  = enable && !active && go_ok && !tx_empty;
  wire reload = enable && last && more;
  wire load   = start | reload;
  wire samp   = tick && (cpha ? !lead : lead);
  wire drv    = tick && !last && (cpha ? lead : !lead);

  wire [15:0] word    = rx_only ? 16'h0 : tx_data;
  wire [15:0] aligned = word << (5'd16 - size);
  wire [15:0] rnext   = {rsh[14:0], miso};
  wire [15:0] mask    = 16'hFFFF >> (5'd16 - size);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      active <= 1'b0;
      sclk_q <= 1'b0;
      mosi_q <= 1'b0;
      push_q <= 1'b0;
      hcnt   <= '0;
      edge_i <= '0;
      sh     <= '0;
      rsh    <= '0;
      rx_q   <= '0;
      left   <= '0;
    end else begin
      push_q <= 1'b0;
      if (tick) begin
        hcnt   <= '0;
        sclk_q <= ~sclk_q;
        edge_i <= edge_i + 6'd1;
        if (samp) rsh <= rnext;
        if (drv) begin
          mosi_q <= sh[15];
          sh     <= sh << 1;
        end
      end else if (active) begin
        hcnt <= hcnt + HONE;
      end
      if (enable && last) begin
        push_q <= ~tx_only;
        rx_q   <= (samp ? rnext : rsh) & mask;
        if (!more) active <= 1'b0;
      end
      if (load) begin
        active <= 1'b1;
        hcnt   <= '0;
        edge_i <= '0;
        sclk_q <= cpol;
        rsh    <= '0;
        if (!cpha) begin
          mosi_q <= aligned[15];
          sh     <= aligned << 1;
        end else begin
          sh <= aligned;
        end
        if (start) left <= cfg_cnt;
        else if (rx_only) left <= left - CONE;
      end
      if (!enable) active <= 1'b0;
    end

  assign tx_pop     = start | (reload & ~rx_only);
  assign rx_push    = push_q;
  assign rx_data    = rx_q;
  assign fifo_flush = ~enable;
  assign busy       = active | ~tx_empty;
  assign sclk       = active ? sclk_q : cpol;
  assign mosi       = active & mosi_q;
  assign ss_n       = active ? ~cfg_sel : '1;
endmodule

// File: rtl/spi_shift_master_chk.sv
module spi_shift_master_chk #(
  parameter int SLAVES = 4,
  parameter int DIVW   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              tx_empty,
  input logic              tx_pop,
  input logic              rx_push,
  input logic              busy,
  input logic              sclk,
  input logic              cpol,
  input logic              txonly,
  input logic [DIVW-1:0]   div_q,
  input logic [SLAVES-1:0] ss_n
);
  AST_IDLE_CLOCK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> sclk == cpol); // R2
  AST_SMALL_DIV_NO_START: assert property (@(posedge clk) disable iff (!rst_n) (div_q[DIVW-1:1] == '0) |-> !tx_pop); // R3
  AST_TXONLY_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n) txonly |-> !rx_push); // R4
  AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n) tx_pop |-> !tx_empty); // R5
  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> &ss_n); // R7
  AST_DISABLE_HALTS: assert property (@(posedge clk) disable iff (!rst_n) !enable |=> (&ss_n) && !rx_push); // R9
  AST_PUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) rx_push |=> !rx_push); // R11
endmodule

bind spi_shift_master spi_shift_master_chk #(.SLAVES(SLAVES), .DIVW(DIVW)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .tx_empty(tx_empty), .tx_pop(tx_pop),
  .rx_push(rx_push), .busy(busy), .sclk(sclk), .cpol(cfg_ctrl[7]),
  .txonly(cfg_ctrl[9:8] == 2'd1), .div_q(cfg_div), .ss_n(ss_n)
);

// File: tb/spi_shift_master_bench.sv
`timescale 1ns/100ps
module spi_shift_master_bench;
  localparam int SLAVES = 3;
  localparam int DIVW   = 6;
  localparam int CNTW   = 4;

  logic clk = 0, rst_n = 0, enable = 0, miso = 0;
  logic [9:0] ctrl_word = '0;
  logic [DIVW-1:0] clk_div = '0;
  logic [SLAVES-1:0] slave_sel = '0;
  logic [CNTW-1:0] frame_cnt = '0;
  logic tx_empty = 1;
  logic [15:0] tx_data = '0;
  logic tx_pop, rx_push, fifo_flush, busy, sclk, mosi;
  logic [15:0] rx_data;
  logic [SLAVES-1:0] ss_n;

  spi_shift_master #(.SLAVES(SLAVES), .DIVW(DIVW), .CNTW(CNTW)) u_spi_shift_master (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ctrl_word(ctrl_word), .clk_div(clk_div),
    .slave_sel(slave_sel), .frame_cnt(frame_cnt), .tx_empty(tx_empty), .tx_data(tx_data),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_data), .fifo_flush(fifo_flush),
    .busy(busy), .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n));

  always #2 clk = ~clk;

  int tests = 0, fails = 0, npush = 0;
  bit checking = 0;
  logic [15:0] txq[$];
  logic [15:0] lfsr = 16'hACE1;

  int m_ctrl, m_div, m_sel, m_cnt, m_act, m_t, m_word, m_rx, m_rxd, m_left, m_mosi, m_push;

  task automatic chk(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int sz();     return (m_ctrl & 15) + 1; endfunction
  function automatic int half();   return m_div / 2; endfunction
  function automatic int cpha();   return (m_ctrl >> 6) & 1; endfunction
  function automatic int cpol();   return (m_ctrl >> 7) & 1; endfunction
  function automatic int mode();   return (m_ctrl >> 8) & 3; endfunction
  function automatic int ok();     return (((m_ctrl >> 4) & 3) == 0) && (half() != 0); endfunction
  function automatic int more();   return (mode() == 2) ? (m_left != 0) : (txq.size() > 0); endfunction
  function automatic int bitk(int k); return (m_word >> (sz() - 1 - k)) & 1; endfunction

  function automatic void load_frame(int first);
    m_word = (mode() == 2) ? 0 : int'(txq[0]);
    m_t = 0; m_rx = 0; m_act = 1;
    if (first) m_left = m_cnt;
    if (cpha() == 0) m_mosi = bitk(0);
  endfunction

  function automatic int exp_pop();
    int nt;
    if (!enable) return 0;
    if (!m_act) return ok() && txq.size() > 0;
    nt = m_t + 1;
    return (nt % half() == 0) && (nt / half() == 2 * sz()) && more() && mode() != 2;
  endfunction

  always @(posedge clk) begin
    int pop_now, flush_now;
    pop_now = 0; flush_now = 0; m_push = 0;
    if (!rst_n) begin
      m_ctrl = 0; m_div = 0; m_sel = 0; m_cnt = 0; m_act = 0; m_t = 0;
      m_word = 0; m_rx = 0; m_rxd = 0; m_left = 0; m_mosi = 0;
    end else if (!enable) begin
      m_act = 0; m_ctrl = ctrl_word; m_div = clk_div; m_sel = slave_sel; m_cnt = frame_cnt;
      flush_now = 1;
    end else if (!m_act) begin
      if (ok() && txq.size() > 0) begin pop_now = 1; load_frame(1); end
    end else begin
      int nt, j;
      nt = m_t + 1; m_t = nt;
      if (nt % half() == 0) begin
        j = nt / half();
        if ((cpha() == 0 && j % 2 == 1) || (cpha() == 1 && j % 2 == 0)) m_rx = (m_rx << 1) | int'(miso);
        if (j == 2 * sz()) begin
          m_push = (mode() != 1);
          m_rxd = m_rx & ((1 << sz()) - 1);
          if (more()) begin
            if (mode() != 2) pop_now = 1; else m_left--;
            load_frame(0);
          end else m_act = 0;
        end else if (cpha() == 0 && j % 2 == 0) m_mosi = bitk(j / 2);
        else if (cpha() == 1 && j % 2 == 1) m_mosi = bitk((j - 1) / 2);
      end
    end
    #0.5;
    if (flush_now) txq.delete();
    else if (pop_now) void'(txq.pop_front());
    tx_empty = (txq.size() == 0);
    tx_data = tx_empty ? 16'h0 : txq[0];
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    miso = lfsr[0];
  end

  always @(negedge clk) if (rst_n && checking) begin
    int es;
    es = m_act ? (cpol() ^ ((m_t / half()) % 2)) : cpol();
    chk("R2", "sclk", int'(sclk), es);
    chk("R1", "mosi", int'(mosi), m_act ? m_mosi : 0);
    chk("R6", "ss_n", int'(ss_n), m_act ? ((~m_sel) & ((1 << SLAVES) - 1)) : (1 << SLAVES) - 1);
    chk("R6", "tx_pop", int'(tx_pop), exp_pop());
    chk("R7", "busy", int'(busy), m_act || txq.size() > 0);
    chk("R9", "fifo_flush", int'(fifo_flush), int'(!enable));
    chk("R11", "rx_push", int'(rx_push), m_push);
    if (rx_push) begin npush++; chk("R11", "rx_data", int'(rx_data), m_rxd); end
  end

  function automatic logic [9:0] mk(int n, int fmt, int ph, int pl, int md);
    return 10'((md << 8) | (pl << 7) | (ph << 6) | (fmt << 4) | (n - 1));
  endfunction

  task automatic cfg(logic [9:0] c, int d, int s, int n);
    @(posedge clk); #1 enable = 0;
    repeat (2) @(posedge clk);
    #1 ctrl_word = c; clk_div = DIVW'(d); slave_sel = SLAVES'(s); frame_cnt = CNTW'(n);
    repeat (2) @(posedge clk);
    #1 enable = 1;
  endtask

  task automatic push(logic [15:0] w);
    @(posedge clk); #1 txq.push_back(w); tx_empty = 0; tx_data = txq[0];
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (!busy && txq.size() == 0) break;
    end
    repeat (2) @(posedge clk);
  endtask

  task automatic run();
    int p0;
    repeat (3) @(negedge clk);
    chk("R12", "reset ss_n", int'(ss_n), 7);
    chk("R12", "reset sclk", int'(sclk), 0);
    chk("R12", "reset mosi", int'(mosi), 0);
    chk("R12", "reset tx_pop", int'(tx_pop), 0);
    chk("R12", "reset rx_push", int'(rx_push), 0);
    @(posedge clk); #1 rst_n = 1; checking = 1;

    cfg(mk(8, 0, 0, 0, 0), 4, 1, 0);                     // R1 R2 8-bit mode 0
    push(16'h00A5); push(16'h003C); push(16'h00FF); wait_idle();

    p0 = npush;                                         // R4 transmit only, R2 phase/polarity 1, R3 odd divider
    cfg(mk(16, 0, 1, 1, 1), 7, 2, 0);
    push(16'hBEEF); push(16'h1234); wait_idle();
    chk("R4", "tx-only pushes", npush - p0, 0);

    cfg(mk(5, 0, 1, 0, 0), 2, 4, 0);                     // R1 odd size, fastest clock
    push(16'h0015); push(16'h000A); push(16'h001F); wait_idle();

    p0 = npush;                                         // R5 receive only, 4 frames
    cfg(mk(8, 0, 0, 1, 2), 2, 1, 3);
    push(16'h00FF); wait_idle();
    chk("R5", "rx-only frames", npush - p0, 4);

    p0 = npush;                                         // R4 mode 3 acts as transmit and receive
    cfg(mk(12, 0, 0, 0, 3), 4, 2, 0);
    push(16'h0ABC); push(16'h0123); wait_idle();
    chk("R4", "mode-3 pushes", npush - p0, 2);

    p0 = npush;                                         // R8 changes while enabled are ignored
    cfg(mk(8, 0, 0, 0, 0), 4, 1, 0);
    @(posedge clk); #1 ctrl_word = mk(16, 1, 1, 1, 1); clk_div = 6'd0; slave_sel = 3'b100;
    push(16'h0055); push(16'h00AA); wait_idle();
    chk("R8", "ignored config pushes", npush - p0, 2);

    cfg(mk(8, 1, 0, 0, 0), 4, 1, 0);                     // R10 non-SPI format
    push(16'h0077); repeat (40) @(negedge clk);
    chk("R10", "word kept", txq.size(), 1);
    chk("R10", "no select", int'(ss_n), 7);

    cfg(mk(8, 0, 0, 0, 0), 1, 1, 0);                     // R3 divider below 2
    push(16'h0066); repeat (40) @(negedge clk);
    chk("R3", "word kept", txq.size(), 1);
    chk("R3", "no select", int'(ss_n), 7);

    cfg(mk(16, 0, 0, 0, 0), 6, 2, 0);                    // R9 disable mid-burst
    push(16'hF00D); push(16'hCAFE); repeat (30) @(posedge clk);
    #1 enable = 0;
    @(negedge clk);
    chk("R9", "flush", int'(fifo_flush), 1);
    @(negedge clk);
    chk("R9", "halted ss_n", int'(ss_n), 7);
    chk("R9", "fifo emptied", txq.size(), 0);

    cfg(mk(16, 0, 0, 0, 0), 2, 4, 0);                    // R1 16-bit back-to-back
    push(16'h8001); push(16'h7FFE); push(16'hA55A); wait_idle();
    @(posedge clk); #1 enable = 0;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    fork
      run();
      begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R7 watchdog: actual hung expected idle");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule